// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Control

This block steers the operand multiplexers of a five-stage in-order pipeline. For each of the two source operands of the instruction in decode it chooses the value's source. The choices are the register file or the result held in the execute, memory or writeback stage. It also raises a stall when a needed value cannot be forwarded yet. The block is purely combinational: each stage presents an opcode class and a destination field, and decode presents its source fields with their read-enables.

Execute results can be forwarded only for register-register and register-immediate ALU operations. A load, or a link jump, sitting in execute has no usable result on that cycle. A decode instruction that depends on one must wait one cycle and then take the value from the memory stage. Link jumps always write the top register, whatever their destination field holds. When several stages write the same register, the youngest writer supplies the value.

Top module: `bypass_ctl`

## Requirements
- R1: With no matching writer in any later stage, both selects are 2'b00 (register file) and stall is 0.
- R2: Opcode class codes are: 0 none, 1 ALU register, 2 ALU immediate, 3 load, 4 jump-and-link, 5 register jump-and-link, 6 store, 7 branch. A read-enabled nonzero source equal to the destination of an execute-stage class 1 or 2 gives select 2'b01 and no stall.
- R3: A read-enabled nonzero source equal to the destination of a memory-stage writer (class 1 to 5) gives select 2'b10.
- R4: A read-enabled nonzero source equal to the destination of a writeback-stage writer (class 1 to 5) gives select 2'b11.
- R5: When several stages match, execute takes priority over memory, and memory takes priority over writeback.
- R6: A source field of register 0 never selects a bypass and never stalls, even if a stage names register 0 as its destination.
- R7: A source whose read-enable is 0 gets select 2'b00 and causes no stall.
- R8: A read-enabled nonzero source that matches an execute-stage load destination raises stall. Its select is 2'b00, even if an older stage also matches.
- R9: Classes 4 and 5 write the all-ones register (31 by default) whatever their destination field. In execute they stall a dependent source. In memory or writeback they forward from that stage.
- R10: Classes 0, 6 and 7 never match in any stage.
- R11: Operand B follows the same rules using its own source field and read-enable, independently of operand A.
- R12: In a moving pipeline, an ALU result used by the next instruction costs no bubble. A load result used by the next instruction costs exactly one bubble, after which the value is forwarded from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | AW | Decode first source register |
| dec_src_b | input | AW | Decode second source register |
| dec_rd_a | input | 1 | First source is read |
| dec_rd_b | input | 1 | Second source is read |
| ex_kind | input | 3 | Execute opcode class |
| ex_dst | input | AW | Execute destination field |
| mem_kind | input | 3 | Memory opcode class |
| mem_dst | input | AW | Memory destination field |
| wb_kind | input | 3 | Writeback opcode class |
| wb_dst | input | AW | Writeback destination field |
| fwd_a | output | 2 | First operand source select |
| fwd_b | output | 2 | Second operand source select |
| stall | output | 1 | Hold decode, insert a bubble into execute |

## Verification
Both selects and the stall are combinational, so they are due in the same cycle that the stage fields are presented. Each directed check drives the inputs and samples the outputs 1 ns later, well before the next clock edge. The pipeline scenarios keep a small stage model inside the bench that advances at each rising edge. The bench presents the model's stage contents after each advance and reads the stall and selects midway through the cycle. It counts bubbles and records the select seen when the dependent instruction leaves decode.

// File: rtl/bypass_ctl.sv
module bypass_ctl #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] dec_src_a,
  input  logic [AW-1:0] dec_src_b,
  input  logic          dec_rd_a,
  input  logic          dec_rd_b,
  input  logic [2:0]    ex_kind,
  input  logic [AW-1:0] ex_dst,
  input  logic [2:0]    mem_kind,
  input  logic [AW-1:0] mem_dst,
  input  logic [2:0]    wb_kind,
  input  logic [AW-1:0] wb_dst,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall
);
  localparam logic [AW-1:0] ZERO = '0;
  localparam logic [AW-1:0] LINK = '1;
  localparam logic [2:0] K_ALU  = 3'd1;
  localparam logic [2:0] K_ALUI = 3'd2;
  localparam logic [2:0] K_LOAD = 3'd3;
  localparam logic [2:0] K_JAL  = 3'd4;
  localparam logic [2:0] K_JALR = 3'd5;
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_EX  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [1:0] SEL_WB  = 2'b11;

  function automatic logic is_link(input logic [2:0] k);
    return k == K_JAL || k == K_JALR;
  endfunction

  function automatic logic writes(input logic [2:0] k);
    return k == K_ALU || k == K_ALUI || k == K_LOAD || is_link(k);
  endfunction

  function automatic logic [AW-1:0] dest(input logic [2:0] k, input logic [AW-1:0] d);
    return is_link(k) ? LINK : d;
  endfunction

  logic [AW-1:0] ex_d, mem_d, wb_d;
  logic ex_fwd, ex_hold, mem_we, wb_we;

  assign ex_d    = dest(ex_kind, ex_dst);
  assign mem_d   = dest(mem_kind, mem_dst);
  assign wb_d    = dest(wb_kind, wb_dst);
  assign ex_fwd  = (ex_kind == K_ALU || ex_kind == K_ALUI) && ex_dst != ZERO;
  assign ex_hold = (ex_kind == K_LOAD && ex_dst != ZERO) || is_link(ex_kind);
  assign mem_we  = writes(mem_kind) && mem_d != ZERO;
  assign wb_we   = writes(wb_kind) && wb_d != ZERO;

  logic [1:0][AW-1:0] src;
  logic [1:0]         rd;
  logic [1:0][1:0]    sel;
  logic [1:0]         hold;

  assign src = {dec_src_b, dec_src_a};
  assign rd  = {dec_rd_b, dec_rd_a};

  for (genvar i = 0; i < 2; i++) begin : g_op
    logic live, hit_e, hit_m, hit_w;
    assign live  = rd[i] && src[i] != ZERO;
    assign hit_e = live && src[i] == ex_d && (ex_fwd || ex_hold);
    assign hit_m = live && src[i] == mem_d && mem_we;
    assign hit_w = live && src[i] == wb_d && wb_we;
    assign sel[i] = hit_e ? (ex_fwd ? SEL_EX : SEL_RF) :
                    hit_m ? SEL_MEM :
                    hit_w ? SEL_WB : SEL_RF;
    assign hold[i] = hit_e && ex_hold;

    always_comb begin
      assert_ex_alu_only_R2: assert (sel[i] != SEL_EX || ex_kind == K_ALU || ex_kind == K_ALUI);
      assert_mem_writer_R3: assert (sel[i] != SEL_MEM || writes(mem_kind));
      assert_wb_writer_R4: assert (sel[i] != SEL_WB || writes(wb_kind));
      assert_zero_src_R6: assert (src[i] != ZERO || (sel[i] == SEL_RF && !hold[i]));
      assert_unread_R7: assert (rd[i] || (sel[i] == SEL_RF && !hold[i]));
      assert_hold_no_bypass_R8: assert (!hold[i] || sel[i] == SEL_RF);
    end
  end

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];
  assign stall = |hold;

  always_comb begin
    assert_stall_cause_R8: assert (!stall || ex_kind == K_LOAD || is_link(ex_kind));
  end
endmodule

// File: tb/bypass_ctl_tb.sv
module bypass_ctl_tb;
  logic clk = 0;
  always #2 clk = ~clk;

  logic [4:0] sa = 0, sb = 0, ed = 0, md = 0, wd = 0;
  logic ra = 0, rb = 0;
  logic [2:0] ek = 0, mk = 0, wk = 0;
  logic [1:0] fa, fb;
  logic st;
  int total = 0, bad = 0;
  bit finished = 0;

  bypass_ctl u_dut (.dec_src_a(sa), .dec_src_b(sb), .dec_rd_a(ra), .dec_rd_b(rb),
    .ex_kind(ek), .ex_dst(ed), .mem_kind(mk), .mem_dst(md), .wb_kind(wk), .wb_dst(wd),
    .fwd_a(fa), .fwd_b(fb), .stall(st));

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic put(input logic [4:0] a, input logic rea, input logic [4:0] b, input logic reb,
                     input logic [2:0] k1, input logic [4:0] d1, input logic [2:0] k2,
                     input logic [4:0] d2, input logic [2:0] k3, input logic [4:0] d3);
    @(negedge clk);
    sa = a; ra = rea; sb = b; rb = reb;
    ek = k1; ed = d1; mk = k2; md = d2; wk = k3; wd = d3;
    #1;
  endtask

  task automatic t_idle;
    put(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 idle a", fa, 0); chk("R1 idle b", fb, 0); chk("R1 idle stall", st, 0);
    put(3, 1, 4, 1, 1, 7, 3, 8, 2, 9);
    chk("R1 nomatch a", fa, 0); chk("R1 nomatch b", fb, 0); chk("R1 nomatch stall", st, 0);
  endtask

  task automatic t_stages;
    put(5, 1, 0, 0, 1, 5, 0, 0, 0, 0); chk("R2 ex alu", fa, 1); chk("R2 no stall", st, 0);
    put(5, 1, 0, 0, 2, 5, 0, 0, 0, 0); chk("R2 ex alui", fa, 1);
    put(6, 1, 0, 0, 0, 0, 3, 6, 0, 0); chk("R3 mem load", fa, 2); chk("R3 no stall", st, 0);
    put(6, 1, 0, 0, 0, 0, 0, 0, 2, 6); chk("R4 wb", fa, 3);
  endtask

  task automatic t_priority;
    put(7, 1, 0, 0, 1, 7, 1, 7, 1, 7); chk("R5 ex first", fa, 1);
    put(7, 1, 0, 0, 0, 0, 3, 7, 1, 7); chk("R5 mem over wb", fa, 2);
  endtask

  task automatic t_zero_and_enable;
    put(0, 1, 0, 1, 3, 0, 1, 0, 1, 0);
    chk("R6 zero a", fa, 0); chk("R6 zero b", fb, 0); chk("R6 zero stall", st, 0);
    put(9, 0, 9, 0, 3, 9, 1, 9, 1, 9);
    chk("R7 unread a", fa, 0); chk("R7 unread b", fb, 0); chk("R7 unread stall", st, 0);
  endtask

  task automatic t_load_and_link;
    put(10, 1, 0, 0, 3, 10, 1, 10, 0, 0);
    chk("R8 load stall", st, 1); chk("R8 load sel", fa, 0);
    put(31, 1, 0, 0, 4, 2, 0, 0, 0, 0); chk("R9 jal ex stall", st, 1);
    put(2, 1, 0, 0, 5, 2, 0, 0, 0, 0); chk("R9 link field ignored", st, 0);
    put(31, 1, 0, 0, 0, 0, 5, 0, 0, 0); chk("R9 link mem", fa, 2);
    put(31, 1, 0, 0, 0, 0, 0, 0, 4, 3); chk("R9 link wb", fa, 3);
  endtask

  task automatic t_nonwriters;
    put(12, 1, 12, 1, 6, 12, 7, 12, 0, 12);
    chk("R10 a", fa, 0); chk("R10 b", fb, 0); chk("R10 stall", st, 0);
  endtask

  task automatic t_operand_b;
    put(4, 1, 8, 1, 1, 8, 1, 4, 0, 0);
    chk("R11 b ex", fb, 1); chk("R11 a mem", fa, 2);
    put(0, 0, 8, 1, 3, 8, 0, 0, 0, 0); chk("R11 b load stall", st, 1);
  endtask

  task automatic run_pipe(input logic [2:0] pk, input int exp_bub, input int exp_sel);
    logic [2:0] dk, ekm, mkm, wkm;
    logic [4:0] dd, edm, mdm, wdm, ds;
    logic dre;
    int stage, bub, issue_sel;
    stage = 0; bub = 0; issue_sel = -1;
    ekm = 0; edm = 0; mkm = 0; mdm = 0; wkm = 0; wdm = 0;
    dk = pk; dd = 5; ds = 0; dre = 0;
    for (int c = 0; c < 10 && issue_sel < 0; c++) begin
      @(negedge clk);
      sa = ds; ra = dre; sb = 0; rb = 0;
      ek = ekm; ed = edm; mk = mkm; md = mdm; wk = wkm; wd = wdm;
      #1;
      if (stage == 1) begin
        if (st) bub++;
        else issue_sel = fa;
      end
      @(posedge clk);
      wkm = mkm; wdm = mdm; mkm = ekm; mdm = edm;
      if (st) begin
        ekm = 0; edm = 0;
      end else begin
        ekm = dk; edm = dd;
        stage++;
        if (stage == 1) begin dk = 1; dd = 6; ds = 5; dre = 1; end
        else begin dk = 0; dd = 0; ds = 0; dre = 0; end
      end
    end
    chk("R12 bubbles", bub, exp_bub);
    chk("R12 issue select", issue_sel, exp_sel);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_stages();
    t_priority();
    t_zero_and_enable();
    t_load_and_link();
    t_nonwriters();
    t_operand_b();
    run_pipe(3'd1, 0, 1);
    run_pipe(3'd3, 1, 2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule